// File: doc/BRIEF.md
# Audio Link Receive Slot Packer

This block sits behind the frame deserializer of an AC'97-style audio link. It serves one receive channel. When a frame has been recovered, the deserializer presents all of that frame's 20-bit slot words at once, with a one-cycle strobe. The block then walks the slots from the lowest number to the highest, one slot per clock. It keeps only the slots that this channel has enabled and that no lower-numbered channel has also claimed. Each kept slot is cut down to the configured sample width and written into a 32-bit-wide receive FIFO.

For 12- and 16-bit samples a compact mode can be set. In that mode two consecutive samples share one FIFO word. A disable mode shrinks the FIFO to a single holding register. The CPU side reads the FIFO through a show-ahead data port and a read strobe, and it sees empty, full and a sticky overrun flag.

The configuration inputs are the masks, the size code, the compact bit and the disable bit. They are meant to stay fixed while traffic flows and are changed only around a reset.

Top module: `rx_slot_packer`

## Requirements
- R1: The size code selects the sample width: 00 gives 12 bits, 11 gives 16 bits, 01 gives 18 bits and 10 gives 20 bits. A sample is the top bits of its 20-bit slot, right-justified, with every higher bit of the word zero.
- R2: Slot i is carried in `slotData[20*i+19:20*i]` and is enabled by bit i of a channel's mask. Within one frame, the enabled slots reach the FIFO in ascending slot number.
- R3: Channel c's mask is `chanMasks[c*SLOTS +: SLOTS]` and this block serves channel `CH_SEL`. A slot that a lower-numbered channel also enables is not written by this block.
- R4: With compact mode set and a 12- or 16-bit width, the first of two samples fills word bits [15:0] and the second fills bits [31:16]. Each sample is zero-extended within its half.
- R5: At 18- or 20-bit widths the compact bit has no effect, and each sample takes its own word.
- R6: In compact mode, a lone first sample left over at the end of a frame is held. It pairs with the next enabled sample of a later frame.
- R7: The FIFO returns words first-in first-out. `rdData` shows the oldest word while `empty` is 0, and a high `rdEn` removes it at the clock edge. `full` rises after `DEPTH` words.
- R8: With `fifoDisable` at 1, the buffer holds one word. `full` rises after one write.
- R9: A word produced while the buffer is full is discarded, and `overrun` goes to 1 and stays there until reset.
- R10: After reset, `empty` is 1 and both `full` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameValid | input | 1 | One-cycle strobe: a new frame is present on slotData |
| slotData | input | SLOTS*20 | All slot words of the frame, slot i at bits 20*i+19..20*i |
| chanMasks | input | NUM_CH*SLOTS | Slot-enable masks of every receive channel |
| sizeCode | input | 2 | Sample width select |
| compactEn | input | 1 | Pack two short samples per word |
| fifoDisable | input | 1 | Use a single holding register instead of the FIFO |
| rdEn | input | 1 | Read strobe, removes the head word |
| rdData | output | 32 | Head word of the FIFO |
| empty | output | 1 | No word is stored |
| full | output | 1 | No space for another word |
| overrun | output | 1 | Sticky: a word was discarded |

## Verification
A wrong scan pointer or a wrong mask snapshot shows up at the read port once the frame has been walked, about SLOTS cycles after the strobe. The symptom is a slot that is missing, doubled or out of order. A stale half-word flag shows up in compact mode as swapped halves, or as a word that appears a frame early or late. A wrong FIFO count shows up right away in `empty`/`full`, or as a wrong overrun after a burst larger than the buffer.

// File: rtl/rx_slot_packer_pkg.sv
package rx_slot_packer_pkg;

  localparam int SLOT_W = 20;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    SZ12 = 2'b00,
    SZ18 = 2'b01,
    SZ20 = 2'b10,
    SZ16 = 2'b11
  } sizeSel_e;

  typedef struct packed {
    logic             capture;
    logic             take;
    logic [IDX_W-1:0] slotIdx;
  } packStrobe_t;

  function automatic logic [WORD_W-1:0] trimSlot(input logic [SLOT_W-1:0] slot,
                                                 input sizeSel_e sz);
    logic [WORD_W-1:0] w;
    case (sz)
      SZ12:    w = WORD_W'(slot[19:8]);
      SZ16:    w = WORD_W'(slot[19:4]);
      SZ18:    w = WORD_W'(slot[19:2]);
      default: w = WORD_W'(slot);
    endcase
    return w;
  endfunction

  function automatic logic isShort(input sizeSel_e sz);
    return (sz == SZ12) || (sz == SZ16);
  endfunction

endpackage

// File: rtl/rx_slot_scan_ctrl.sv
module rx_slot_scan_ctrl
  import rx_slot_packer_pkg::*;
#(
  parameter int SLOTS  = 12,
  parameter int NUM_CH = 4,
  parameter int CH_SEL = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameValid,
  input  logic [NUM_CH*SLOTS-1:0] chanMasks,
  output packStrobe_t             strobe
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

  logic [SLOTS-1:0] orStage [NUM_CH+1];
  logic [SLOTS-1:0] effMask;
  logic [SLOTS-1:0] maskReg;
  logic [IW-1:0]    ptr;
  logic             active;

  assign orStage[0] = '0;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_lower
    if (c < CH_SEL) begin : g_claim
      assign orStage[c+1] = orStage[c] | chanMasks[c*SLOTS +: SLOTS];
    end else begin : g_pass
      assign orStage[c+1] = orStage[c];
    end
  end

  assign effMask = chanMasks[CH_SEL*SLOTS +: SLOTS] & ~orStage[NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      ptr     <= '0;
      active  <= 1'b0;
    end else if (frameValid) begin
      maskReg <= effMask;
      ptr     <= '0;
      active  <= 1'b1;
    end else if (active) begin
      if (ptr == LAST) begin
        active <= 1'b0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  assign strobe.capture = frameValid;
  assign strobe.take    = active && maskReg[ptr];
  assign strobe.slotIdx = IDX_W'(ptr);

  initial begin
    if (SLOTS > (1 << IDX_W)) $error("SLOTS exceeds index width");
  end

  p_scan_ends_r2: assert property (@(posedge clk) disable iff (!rstN)
    active && (ptr == LAST) && !frameValid |=> !active);

  p_scan_ascends_r2: assert property (@(posedge clk) disable iff (!rstN)
    active && !frameValid && (ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

endmodule

// File: rtl/rx_slot_pack_data.sv
module rx_slot_pack_data
  import rx_slot_packer_pkg::*;
#(
  parameter int SLOTS = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  packStrobe_t             strobe,
  input  logic [SLOTS*SLOT_W-1:0] slotData,
  input  logic [1:0]              sizeCode,
  input  logic                    compactEn,
  output logic                    pushWord,
  output logic [WORD_W-1:0]       wordOut
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOT_W-1:0] frameReg [SLOTS];
  logic [WORD_W-1:0] sample;
  logic [15:0]       halfReg;
  logic              halfPend;
  logic              compactEff;
  sizeSel_e          sz;

  assign sz = sizeSel_e'(sizeCode);
  assign compactEff = compactEn && isShort(sz);

  for (genvar i = 0; i < SLOTS; i++) begin : g_frame
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        frameReg[i] <= '0;
      end else if (strobe.capture) begin
        frameReg[i] <= slotData[i*SLOT_W +: SLOT_W];
      end
    end
  end

  assign sample = trimSlot(frameReg[strobe.slotIdx[IW-1:0]], sz);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfReg  <= '0;
      halfPend <= 1'b0;
    end else if (strobe.take && compactEff) begin
      if (!halfPend) begin
        halfReg  <= sample[15:0];
        halfPend <= 1'b1;
      end else begin
        halfPend <= 1'b0;
      end
    end
  end

  always_comb begin
    pushWord = 1'b0;
    wordOut  = sample;
    if (strobe.take) begin
      if (compactEff) begin
        pushWord = halfPend;
        wordOut  = {sample[15:0], halfReg};
      end else begin
        pushWord = 1'b1;
      end
    end
  end

  p_trim_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    pushWord && !compactEff |-> wordOut[31:20] == '0);

  p_pair_push_r4: assert property (@(posedge clk) disable iff (!rstN)
    pushWord && compactEff |=> !halfPend);

endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fifoDisable,
  input  logic         push,
  input  logic [W-1:0] wrData,
  input  logic         rdEn,
  output logic [W-1:0] rdData,
  output logic         empty,
  output logic         full,
  output logic         overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic [CW-1:0] cap;
  logic          doPush, doPop;

  assign cap    = fifoDisable ? CW'(1) : CW'(DEPTH);
  assign empty  = (count == '0);
  assign full   = (count >= cap);
  assign doPush = push && !full;
  assign doPop  = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) overrun <= 1'b1;
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  p_single_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoDisable && $stable(fifoDisable) |-> count <= CW'(1));

  p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    push && full && !rdEn |=> count == $past(count));

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

// File: rtl/rx_slot_packer.sv
module rx_slot_packer
  import rx_slot_packer_pkg::*;
#(
  parameter int SLOTS  = 12,
  parameter int NUM_CH = 4,
  parameter int CH_SEL = 1,
  parameter int DEPTH  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameValid,
  input  logic [SLOTS*20-1:0]     slotData,
  input  logic [NUM_CH*SLOTS-1:0] chanMasks,
  input  logic [1:0]              sizeCode,
  input  logic                    compactEn,
  input  logic                    fifoDisable,
  input  logic                    rdEn,
  output logic [31:0]             rdData,
  output logic                    empty,
  output logic                    full,
  output logic                    overrun
);
  packStrobe_t       strobe;
  logic              pushWord;
  logic [WORD_W-1:0] wordOut;

  rx_slot_scan_ctrl #(.SLOTS(SLOTS), .NUM_CH(NUM_CH), .CH_SEL(CH_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid),
    .chanMasks(chanMasks), .strobe(strobe)
  );

  rx_slot_pack_data #(.SLOTS(SLOTS)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotData(slotData),
    .sizeCode(sizeCode), .compactEn(compactEn),
    .pushWord(pushWord), .wordOut(wordOut)
  );

  rx_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rstN(rstN), .fifoDisable(fifoDisable),
    .push(pushWord), .wrData(wordOut), .rdEn(rdEn),
    .rdData(rdData), .empty(empty), .full(full), .overrun(overrun)
  );

endmodule

// File: tb/rx_slot_packer_test.sv
module rx_slot_packer_test;
  localparam int PERIOD = 10;
  localparam int SLOTS  = 12;
  localparam int NUM_CH = 4;
  localparam int CH_SEL = 1;
  localparam int DEPTH  = 8;

  logic                    clk = 1'b0;
  logic                    rstN;
  logic                    frameValid;
  logic [SLOTS*20-1:0]     slotData;
  logic [NUM_CH*SLOTS-1:0] chanMasks;
  logic [1:0]              sizeCode;
  logic                    compactEn, fifoDisable, rdEn;
  logic [31:0]             rdData;
  logic                    empty, full, overrun;

  int nChecks = 0;
  int nFails  = 0;

  always #(PERIOD/2) clk = ~clk;

  rx_slot_packer #(.SLOTS(SLOTS), .NUM_CH(NUM_CH), .CH_SEL(CH_SEL), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .slotData(slotData),
    .chanMasks(chanMasks), .sizeCode(sizeCode), .compactEn(compactEn),
    .fifoDisable(fifoDisable), .rdEn(rdEn), .rdData(rdData),
    .empty(empty), .full(full), .overrun(overrun)
  );

  function automatic logic [19:0] slotVal(input int idx, input int seed);
    logic [31:0] t;
    t = 32'(idx) * 32'h1357B + 32'(seed) * 32'h0F0E1 + 32'h9A4C3;
    return t[19:0];
  endfunction

  function automatic logic [31:0] trimOf(input logic [19:0] v, input logic [1:0] code);
    case (code)
      2'b00:   return 32'(v >> 8);
      2'b11:   return 32'(v >> 4);
      2'b01:   return 32'(v >> 2);
      default: return 32'(v);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] code, input logic cmp, input logic dis);
    @(negedge clk);
    rstN = 1'b0; frameValid = 1'b0; rdEn = 1'b0; chanMasks = '0; slotData = '0;
    sizeCode = code; compactEn = cmp; fifoDisable = dis;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendFrame(input int seed, input logic [SLOTS-1:0] own,
                           input logic [SLOTS-1:0] chan0);
    for (int i = 0; i < SLOTS; i++) slotData[i*20 +: 20] = slotVal(i, seed);
    chanMasks = '0;
    chanMasks[0 +: SLOTS]             = chan0;
    chanMasks[CH_SEL*SLOTS +: SLOTS]  = own;
    frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
    repeat (SLOTS + 2) @(negedge clk);
  endtask

  task automatic popCheck(input string req, input logic [31:0] exp);
    chk(req, {31'b0, empty}, 32'd0);
    chk(req, rdData, exp);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic testReset;
    doReset(2'b10, 1'b0, 1'b0);
    chk("R10 empty", {31'b0, empty}, 32'd1);
    chk("R10 full", {31'b0, full}, 32'd0);
    chk("R10 overrun", {31'b0, overrun}, 32'd0);
  endtask

  task automatic testOrder;
    doReset(2'b10, 1'b0, 1'b0);
    sendFrame(1, 12'b0010_0010_1000, 12'b0);
    popCheck("R2 first slot 3", trimOf(slotVal(3, 1), 2'b10));
    popCheck("R2 then slot 5", trimOf(slotVal(5, 1), 2'b10));
    popCheck("R2 then slot 9", trimOf(slotVal(9, 1), 2'b10));
    chk("R2 drained", {31'b0, empty}, 32'd1);
  endtask

  task automatic testSizes;
    logic [1:0] codes [4];
    codes = '{2'b00, 2'b11, 2'b01, 2'b10};
    foreach (codes[k]) begin
      doReset(codes[k], 1'b0, 1'b0);
      sendFrame(2 + k, 12'b0000_0100_0000, 12'b0);
      popCheck("R1 trim width", trimOf(slotVal(6, 2 + k), codes[k]));
    end
  endtask

  task automatic testContention;
    doReset(2'b10, 1'b0, 1'b0);
    sendFrame(7, 12'b0000_1001_0000, 12'b0000_0001_0000);
    popCheck("R3 unclaimed slot 7", trimOf(slotVal(7, 7), 2'b10));
    chk("R3 slot 4 withheld", {31'b0, empty}, 32'd1);
  endtask

  task automatic testCompact;
    doReset(2'b11, 1'b1, 1'b0);
    sendFrame(8, 12'b0000_0111_1000, 12'b0);
    popCheck("R4 pair 3/4", {trimOf(slotVal(4, 8), 2'b11)[15:0], trimOf(slotVal(3, 8), 2'b11)[15:0]});
    popCheck("R4 pair 5/6", {trimOf(slotVal(6, 8), 2'b11)[15:0], trimOf(slotVal(5, 8), 2'b11)[15:0]});
    doReset(2'b00, 1'b1, 1'b0);
    sendFrame(9, 12'b0001_1000_0000, 12'b0);
    popCheck("R4 12-bit pair", {trimOf(slotVal(8, 9), 2'b00)[15:0], trimOf(slotVal(7, 9), 2'b00)[15:0]});
  endtask

  task automatic testCompactIgnored;
    doReset(2'b01, 1'b1, 1'b0);
    sendFrame(10, 12'b0000_0001_1000, 12'b0);
    popCheck("R5 18-bit slot 3 alone", trimOf(slotVal(3, 10), 2'b01));
    popCheck("R5 18-bit slot 4 alone", trimOf(slotVal(4, 10), 2'b01));
  endtask

  task automatic testOddHold;
    doReset(2'b11, 1'b1, 1'b0);
    sendFrame(11, 12'b0000_0011_1000, 12'b0);
    popCheck("R6 first pair", {trimOf(slotVal(4, 11), 2'b11)[15:0], trimOf(slotVal(3, 11), 2'b11)[15:0]});
    chk("R6 odd half held", {31'b0, empty}, 32'd1);
    sendFrame(12, 12'b0000_1000_0000, 12'b0);
    popCheck("R6 cross-frame pair", {trimOf(slotVal(7, 12), 2'b11)[15:0], trimOf(slotVal(5, 11), 2'b11)[15:0]});
  endtask

  task automatic testHolding;
    doReset(2'b10, 1'b0, 1'b1);
    sendFrame(13, 12'b0000_0011_1000, 12'b0);
    chk("R8 full after one", {31'b0, full}, 32'd1);
    chk("R9 overrun set", {31'b0, overrun}, 32'd1);
    popCheck("R8 held word", trimOf(slotVal(3, 13), 2'b10));
    chk("R8 nothing else kept", {31'b0, empty}, 32'd1);
    chk("R9 overrun sticky", {31'b0, overrun}, 32'd1);
  endtask

  task automatic testOverflow;
    doReset(2'b10, 1'b0, 1'b0);
    sendFrame(14, 12'b0000_1111_1100, 12'b0);
    chk("R7 not full at six", {31'b0, full}, 32'd0);
    chk("R9 no overrun yet", {31'b0, overrun}, 32'd0);
    sendFrame(15, 12'b1111_0000_0000, 12'b0);
    chk("R7 full", {31'b0, full}, 32'd1);
    chk("R9 overrun", {31'b0, overrun}, 32'd1);
    for (int s = 2; s < 8; s++) popCheck("R7 fifo order f1", trimOf(slotVal(s, 14), 2'b10));
    popCheck("R7 fifo order f2 s8", trimOf(slotVal(8, 15), 2'b10));
    popCheck("R7 fifo order f2 s9", trimOf(slotVal(9, 15), 2'b10));
    chk("R9 excess dropped", {31'b0, empty}, 32'd1);
  endtask

  initial begin
    rstN = 1'b0; frameValid = 1'b0; rdEn = 1'b0; chanMasks = '0; slotData = '0;
    sizeCode = 2'b10; compactEn = 1'b0; fifoDisable = 1'b0;
    testReset();
    testOrder();
    testSizes();
    testContention();
    testCompact();
    testCompactIgnored();
    testOddHold();
    testHolding();
    testOverflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule